// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register bank of one 16-pin general-purpose I/O port. A processor reaches it over a 32-bit bus that uses word addresses and a valid/ready handshake, where ready is always high. For every pin the bank holds five settings: a mode, an output type, a speed, a pull selection and an alternate-function number. It also holds a per-pin security attribute, an output data latch, and a synchronized copy of the input pins.

From these settings the bank drives the pad controls for each pin: output value, output enable, open-drain flag and the two pull enables. It also drives a 4-bit alternate-function select for each pin towards an external multiplexer.

A write-only register changes output bits atomically: it sets or clears any group of pins without a read-modify-write. Each pin can be marked secure. A bus access that is flagged non-secure then cannot change that pin's fields and reads them as zero.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads zero. For all pins, pad_oe, pad_pu, pad_pd, pad_od and pad_out are 0, and pad_af is 0.
- R2: Each accepted read returns its data on rd_data in the following cycle, with rd_valid high for that cycle only. Word addresses 0, 1, 2, 3, 8 and 9 read back the settings last written: mode (2 bits at 2n), output type (1 bit at n), speed (2 bits at 2n), pull (2 bits at 2n), alternate function for pins 0-7 (4 bits at 4n) and alternate function for pins 8-15 (4 bits at 4(n-8)).
- R3: A write to word address 6 does the following for each pin n. Bit n set forces the output latch of pin n to 1. Bit n+16 set forces it to 0. When both bits are set, the set wins. When neither is set, the pin keeps its value. A read of address 6 returns zero.
- R4: Word address 5 is the output latch, one bit per pin at bit n. It can be read and written.
- R5: Word address 4 returns pad_in after a two-flop synchronizer. A read accepted in the same cycle as a pin change returns the old value. A read accepted two cycles later returns the new value. Writes to this address have no effect.
- R6: pad_out equals the output latch for every pin. pad_oe is set as follows. Mode 1 (output) gives 1, except that with output type 1 (open-drain) and a latch value of 1 it gives 0. Mode 2 (alternate) gives 1. Mode 0 (input) and mode 3 (analog) give 0.
- R7: Pull value 1 sets pad_pu and pull value 2 sets pad_pd. Values 0 and 3 set neither. pad_od equals the output type bit of the pin.
- R8: pad_af[4n+3:4n] carries the alternate-function number of pin n.
- R9: Word address 12 holds the secure bit of pin n at bit n. Only an access with bus_nonsec = 0 can write it. Non-secure writes to it are ignored. Every access can read it.
- R10: A write with bus_nonsec = 1 leaves unchanged every field of a pin whose secure bit is 1, in all registers, including the set/reset register. Fields of other pins, and all fields written by secure accesses, update normally.
- R11: A read with bus_nonsec = 1 returns zero in the fields of secure pins in the per-pin registers: addresses 0-5, 8 and 9.
- R12: Reads of any word address other than 0-6, 8, 9 and 12 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request valid |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_nonsec | input | 1 | 1 marks the access as non-secure |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| pad_in | input | 16 | Asynchronous input pin levels |
| pad_out | output | 16 | Pad output value per pin |
| pad_oe | output | 16 | Pad output enable per pin |
| pad_od | output | 16 | Open-drain flag per pin |
| pad_pu | output | 16 | Pull-up enable per pin |
| pad_pd | output | 16 | Pull-down enable per pin |
| pad_af | output | 64 | Alternate-function select, 4 bits per pin |

## Verification
The bound checker watches four behaviours on every cycle:
- the read response timing;
- the effect of set/reset writes on the output latch, including set priority;
- the rule that a non-secure write leaves secure pins' mode and latch bits unchanged, and never changes the secure register;
- the zero masking of secure pins in non-secure latch reads, and pad_oe staying low in input and analog modes.

Some behaviours only the bench scenarios can show. These are the reset contents, the two-cycle input synchronizer latency, the read-back layout of the split alternate-function registers, the open-drain release of a high output, the pull decode, and reads of unmapped addresses. A seeded random mix of secure and non-secure accesses is compared against a bench model of every register and pad.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int NPINS  = 16;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int AF_W   = 4;
  localparam int HALF   = NPINS / 2;

  localparam logic [ADDR_W-1:0] A_MODE  = 4'd0;
  localparam logic [ADDR_W-1:0] A_OTYPE = 4'd1;
  localparam logic [ADDR_W-1:0] A_SPEED = 4'd2;
  localparam logic [ADDR_W-1:0] A_PULL  = 4'd3;
  localparam logic [ADDR_W-1:0] A_IDR   = 4'd4;
  localparam logic [ADDR_W-1:0] A_ODR   = 4'd5;
  localparam logic [ADDR_W-1:0] A_BSRR  = 4'd6;
  localparam logic [ADDR_W-1:0] A_AFLO  = 4'd8;
  localparam logic [ADDR_W-1:0] A_AFHI  = 4'd9;
  localparam logic [ADDR_W-1:0] A_SEC   = 4'd12;

  typedef enum logic [1:0] {
    MD_IN  = 2'd0,
    MD_OUT = 2'd1,
    MD_ALT = 2'd2,
    MD_ANA = 2'd3
  } pin_mode_t;

  // Widen a per-pin mask to two bits per pin.
  function automatic logic [2*NPINS-1:0] spread2(input logic [NPINS-1:0] m);
    logic [2*NPINS-1:0] r;
    for (int i = 0; i < NPINS; i++) r[2*i +: 2] = {2{m[i]}};
    return r;
  endfunction

  // Widen a half-port mask to four bits per pin.
  function automatic logic [AF_W*HALF-1:0] spread4(input logic [HALF-1:0] m);
    logic [AF_W*HALF-1:0] r;
    for (int i = 0; i < HALF; i++) r[AF_W*i +: AF_W] = {AF_W{m[i]}};
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                              input logic [DATA_W-1:0] new_v,
                                              input logic [DATA_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction

  // Set/reset update of the output latch; set wins over reset.
  function automatic logic [NPINS-1:0] setrst(input logic [NPINS-1:0] cur,
                                              input logic [DATA_W-1:0] wd,
                                              input logic [NPINS-1:0] allow);
    logic [NPINS-1:0] s, c;
    s = wd[NPINS-1:0] & allow;
    c = wd[DATA_W-1:NPINS] & allow & ~s;
    return (cur | s) & ~c;
  endfunction

  function automatic logic drive_en(input pin_mode_t md, input logic od,
                                    input logic v);
    case (md)
      MD_OUT:  return !(od && v);
      MD_ALT:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else             stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                nonsec,
  input  logic [NPINS-1:0]    idr,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic [2*NPINS-1:0]  mode_q,
  output logic [NPINS-1:0]    otype_q,
  output logic [2*NPINS-1:0]  speed_q,
  output logic [2*NPINS-1:0]  pull_q,
  output logic [NPINS-1:0]    odr_q,
  output logic [AF_W*HALF-1:0] aflo_q,
  output logic [AF_W*HALF-1:0] afhi_q,
  output logic [NPINS-1:0]    sec_q
);
  logic [NPINS-1:0]    allow;
  logic [2*NPINS-1:0]  m2;
  logic [AF_W*HALF-1:0] m4lo, m4hi;
  logic [DATA_W-1:0]   rmux;

  assign allow = nonsec ? ~sec_q : '1;
  assign m2    = spread2(allow);
  assign m4lo  = spread4(allow[HALF-1:0]);
  assign m4hi  = spread4(allow[NPINS-1:HALF]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      odr_q   <= '0;
      aflo_q  <= '0;
      afhi_q  <= '0;
      sec_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        A_MODE:  mode_q  <= merge(mode_q, wdata, m2);
        A_OTYPE: otype_q <= (otype_q & ~allow) | (wdata[NPINS-1:0] & allow);
        A_SPEED: speed_q <= merge(speed_q, wdata, m2);
        A_PULL:  pull_q  <= merge(pull_q, wdata, m2);
        A_ODR:   odr_q   <= (odr_q & ~allow) | (wdata[NPINS-1:0] & allow);
        A_BSRR:  odr_q   <= setrst(odr_q, wdata, allow);
        A_AFLO:  aflo_q  <= merge(aflo_q, wdata, m4lo);
        A_AFHI:  afhi_q  <= merge(afhi_q, wdata, m4hi);
        A_SEC:   if (!nonsec) sec_q <= wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_MODE:  rmux = mode_q & m2;
      A_OTYPE: rmux = {{(DATA_W-NPINS){1'b0}}, otype_q & allow};
      A_SPEED: rmux = speed_q & m2;
      A_PULL:  rmux = pull_q & m2;
      A_IDR:   rmux = {{(DATA_W-NPINS){1'b0}}, idr & allow};
      A_ODR:   rmux = {{(DATA_W-NPINS){1'b0}}, odr_q & allow};
      A_AFLO:  rmux = aflo_q & m4lo;
      A_AFHI:  rmux = afhi_q & m4hi;
      A_SEC:   rmux = {{(DATA_W-NPINS){1'b0}}, sec_q};
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rmux;
    end
  end
endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad
  import gpio_port_pkg::*;
(
  input  logic [2*NPINS-1:0]    mode_q,
  input  logic [NPINS-1:0]      otype_q,
  input  logic [NPINS-1:0]      odr_q,
  input  logic [2*NPINS-1:0]    pull_q,
  input  logic [AF_W*HALF-1:0]  aflo_q,
  input  logic [AF_W*HALF-1:0]  afhi_q,
  output logic [NPINS-1:0]      pad_out,
  output logic [NPINS-1:0]      pad_oe,
  output logic [NPINS-1:0]      pad_od,
  output logic [NPINS-1:0]      pad_pu,
  output logic [NPINS-1:0]      pad_pd,
  output logic [AF_W*NPINS-1:0] pad_af
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pin_mode_t md;
    assign md        = pin_mode_t'(mode_q[2*i +: 2]);
    assign pad_oe[i] = drive_en(md, otype_q[i], odr_q[i]);
    assign pad_pu[i] = (pull_q[2*i +: 2] == 2'd1);
    assign pad_pd[i] = (pull_q[2*i +: 2] == 2'd2);
  end

  assign pad_out = odr_q;
  assign pad_od  = otype_q;
  assign pad_af  = {afhi_q, aflo_q};
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  output logic                  bus_ready,
  input  logic                  bus_write,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_nonsec,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [NPINS-1:0]      pad_in,
  output logic [NPINS-1:0]      pad_out,
  output logic [NPINS-1:0]      pad_oe,
  output logic [NPINS-1:0]      pad_od,
  output logic [NPINS-1:0]      pad_pu,
  output logic [NPINS-1:0]      pad_pd,
  output logic [AF_W*NPINS-1:0] pad_af
);
  logic                  wr_go, rd_go;
  logic [NPINS-1:0]      in_sync;
  logic [2*NPINS-1:0]    cfg_mode, cfg_speed, cfg_pull;
  logic [NPINS-1:0]      cfg_otype, cfg_odr, cfg_sec;
  logic [AF_W*HALF-1:0]  cfg_aflo, cfg_afhi;

  assign bus_ready = 1'b1;
  assign wr_go     = bus_valid & bus_write;
  assign rd_go     = bus_valid & ~bus_write;

  gpio_port_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
  );

  gpio_port_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_go), .rd_en(rd_go),
    .addr(bus_addr), .wdata(bus_wdata), .nonsec(bus_nonsec), .idr(in_sync),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mode_q(cfg_mode), .otype_q(cfg_otype), .speed_q(cfg_speed),
    .pull_q(cfg_pull), .odr_q(cfg_odr), .aflo_q(cfg_aflo),
    .afhi_q(cfg_afhi), .sec_q(cfg_sec)
  );

  gpio_port_pad u_pad (
    .mode_q(cfg_mode), .otype_q(cfg_otype), .odr_q(cfg_odr),
    .pull_q(cfg_pull), .aflo_q(cfg_aflo), .afhi_q(cfg_afhi),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_af(pad_af)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               bus_nonsec,
  input logic               rd_valid,
  input logic [DATA_W-1:0]  rd_data,
  input logic [NPINS-1:0]   pad_oe,
  input logic [2*NPINS-1:0] cfg_mode,
  input logic [NPINS-1:0]   cfg_odr,
  input logic [NPINS-1:0]   cfg_sec
);
  logic [NPINS-1:0] ok_pins;
  logic [NPINS-1:0] set_bits, clr_bits;
  logic             is_rd, is_wr, is_bsrr;

  assign ok_pins  = bus_nonsec ? ~cfg_sec : '1;
  assign set_bits = bus_wdata[NPINS-1:0] & ok_pins;
  assign clr_bits = bus_wdata[DATA_W-1:NPINS] & ok_pins & ~bus_wdata[NPINS-1:0];
  assign is_rd    = bus_valid && !bus_write;
  assign is_wr    = bus_valid && bus_write;
  assign is_bsrr  = is_wr && (bus_addr == A_BSRR);

  p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rd_valid);
  p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> !rd_valid);
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_bsrr |=> ((cfg_odr & $past(set_bits)) == $past(set_bits)));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_bsrr |=> ((cfg_odr & $past(clr_bits)) == '0));
  p_sec_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && bus_nonsec) |=> $stable(cfg_sec));
  p_odr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && bus_nonsec) |=> (((cfg_odr ^ $past(cfg_odr)) & $past(cfg_sec)) == '0));
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && bus_nonsec) |=>
      (((cfg_mode ^ $past(cfg_mode)) & spread2($past(cfg_sec))) == '0));
  p_read_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && bus_nonsec && bus_addr == A_ODR) |=>
      ((rd_data[NPINS-1:0] & $past(cfg_sec)) == '0));

  for (genvar i = 0; i < NPINS; i++) begin : g_oe
    p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode[2*i +: 2] == 2'd0 || cfg_mode[2*i +: 2] == 2'd3) |-> !pad_oe[i]);
  end
endmodule

bind gpio_port gpio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_nonsec(bus_nonsec),
  .rd_valid(rd_valid), .rd_data(rd_data), .pad_oe(pad_oe),
  .cfg_mode(cfg_mode), .cfg_odr(cfg_odr), .cfg_sec(cfg_sec)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, bus_nonsec = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, rd_valid;
  logic [31:0] rd_data;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe, pad_od, pad_pu, pad_pd;
  logic [63:0] pad_af;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [31:0] b_mode, b_speed, b_pull, b_aflo, b_afhi;
  logic [15:0] b_otype, b_odr, b_sec;

  always #2 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_nonsec(bus_nonsec), .rd_valid(rd_valid), .rd_data(rd_data),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_af(pad_af)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mdl_write(input logic [3:0] a, input logic [31:0] d, input bit ns);
    logic [15:0] ok;
    ok = ns ? ~b_sec : 16'hffff;
    if (a == 4'd12) begin
      if (!ns) b_sec = d[15:0];
    end else begin
      for (int p = 0; p < 16; p++) begin
        if (ok[p]) begin
          case (a)
            4'd0: b_mode[2*p +: 2]  = d[2*p +: 2];
            4'd1: b_otype[p]        = d[p];
            4'd2: b_speed[2*p +: 2] = d[2*p +: 2];
            4'd3: b_pull[2*p +: 2]  = d[2*p +: 2];
            4'd5: b_odr[p]          = d[p];
            4'd6: if (d[p]) b_odr[p] = 1'b1; else if (d[16+p]) b_odr[p] = 1'b0;
            4'd8: if (p < 8) b_aflo[4*p +: 4] = d[4*p +: 4];
            4'd9: if (p >= 8) b_afhi[4*(p-8) +: 4] = d[4*(p-8) +: 4];
            default: ;
          endcase
        end
      end
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] a, input bit ns);
    logic [15:0] ok;
    logic [31:0] r;
    ok = ns ? ~b_sec : 16'hffff;
    r = '0;
    for (int p = 0; p < 16; p++) begin
      if (ok[p]) begin
        case (a)
          4'd0: r[2*p +: 2] = b_mode[2*p +: 2];
          4'd1: r[p] = b_otype[p];
          4'd2: r[2*p +: 2] = b_speed[2*p +: 2];
          4'd3: r[2*p +: 2] = b_pull[2*p +: 2];
          4'd4: r[p] = pad_in[p];
          4'd5: r[p] = b_odr[p];
          4'd8: if (p < 8) r[4*p +: 4] = b_aflo[4*p +: 4];
          4'd9: if (p >= 8) r[4*(p-8) +: 4] = b_afhi[4*(p-8) +: 4];
          default: ;
        endcase
      end
    end
    if (a == 4'd12) r = {16'h0, b_sec};
    return r;
  endfunction

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input bit ns);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_nonsec = ns;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    mdl_write(a, d, ns);
  endtask

  task automatic bus_rd(input logic [3:0] a, input bit ns, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_nonsec = ns;
    @(posedge clk); #1;
    chk("R2 rd_valid", {63'h0, rd_valid}, 64'h1);
    d = rd_data;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input bit ns);
    logic [31:0] d;
    bus_rd(a, ns, d);
    chk(tag, {32'h0, d}, {32'h0, exp_read(a, ns)});
  endtask

  task automatic pads_chk(input string tag);
    logic [15:0] e_oe, e_pu, e_pd;
    for (int p = 0; p < 16; p++) begin
      case (b_mode[2*p +: 2])
        2'd1: e_oe[p] = !(b_otype[p] && b_odr[p]);
        2'd2: e_oe[p] = 1'b1;
        default: e_oe[p] = 1'b0;
      endcase
      e_pu[p] = (b_pull[2*p +: 2] == 2'd1);
      e_pd[p] = (b_pull[2*p +: 2] == 2'd2);
    end
    chk({tag, " R6 pad_oe"}, {48'h0, pad_oe}, {48'h0, e_oe});
    chk({tag, " R6 pad_out"}, {48'h0, pad_out}, {48'h0, b_odr});
    chk({tag, " R7 pad_pu"}, {48'h0, pad_pu}, {48'h0, e_pu});
    chk({tag, " R7 pad_pd"}, {48'h0, pad_pd}, {48'h0, e_pd});
    chk({tag, " R7 pad_od"}, {48'h0, pad_od}, {48'h0, b_otype});
    chk({tag, " R8 pad_af"}, pad_af, {b_afhi, b_aflo});
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0] addrs [12];
    int unsigned seed;
    b_mode = 0; b_speed = 0; b_pull = 0; b_aflo = 0; b_afhi = 0;
    b_otype = 0; b_odr = 0; b_sec = 0;
    addrs = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd12, 4'd7, 4'd15};
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    pads_chk("R1 reset");
    for (int a = 0; a < 16; a++) begin
      bus_rd(a[3:0], 1'b0, d);
      chk("R1 reset read", {32'h0, d}, 64'h0);
    end

    // R12 unmapped
    bus_wr(4'd7, 32'hffff_ffff, 1'b0);
    bus_rd(4'd7, 1'b0, d);
    chk("R12 unmapped 7", {32'h0, d}, 64'h0);
    bus_rd(4'd14, 1'b0, d);
    chk("R12 unmapped 14", {32'h0, d}, 64'h0);

    // R2 readback of config registers
    bus_wr(4'd0, 32'h5555_5555, 1'b0);
    bus_wr(4'd2, 32'hdead_beef, 1'b0);
    bus_wr(4'd3, 32'h1b1b_e4e4, 1'b0);
    bus_wr(4'd1, 32'hffff_0f0f, 1'b0);
    bus_wr(4'd8, 32'h7654_3210, 1'b0);
    bus_wr(4'd9, 32'hfedc_ba98, 1'b0);
    rd_chk("R2 mode", 4'd0, 1'b0);
    rd_chk("R2 speed", 4'd2, 1'b0);
    rd_chk("R2 pull", 4'd3, 1'b0);
    rd_chk("R2 otype", 4'd1, 1'b0);
    rd_chk("R2 aflo", 4'd8, 1'b0);
    rd_chk("R2 afhi", 4'd9, 1'b0);
    chk("R8 af pin 9", {60'h0, pad_af[39:36]}, 64'h9);
    chk("R8 af pin 3", {60'h0, pad_af[15:12]}, 64'h3);
    pads_chk("R7 pulls");

    // R4 latch and R6 open-drain release
    bus_wr(4'd5, 32'h0000_00ff, 1'b0);
    rd_chk("R4 odr", 4'd5, 1'b0);
    pads_chk("R6 opendrain");
    chk("R6 od high releases pin0", {63'h0, pad_oe[0]}, 64'h0);
    chk("R6 pushpull high drives pin4", {63'h0, pad_oe[4]}, 64'h1);

    // R3 set/reset with set priority
    bus_wr(4'd6, 32'h0003_0f00, 1'b0);
    chk("R3 set wins", {48'h0, pad_out}, 64'h0ffc);
    bus_wr(4'd6, 32'h00f0_0000, 1'b0);
    chk("R3 reset", {48'h0, pad_out}, 64'h0f0c);
    rd_chk("R3 bsrr reads zero", 4'd6, 1'b0);
    bus_wr(4'd0, 32'hb1b1_b1b1, 1'b0);
    pads_chk("R6 mixed modes");

    // R5 input synchronizer
    @(negedge clk);
    pad_in = 16'ha5c3;
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = 4'd4; bus_nonsec = 0;
    @(posedge clk); #1;
    n_run++;
    @(negedge clk); bus_valid = 0;
    pad_in = 16'h3c5a;
    bus_valid = 1;
    @(posedge clk); #1;
    chk("R5 old value", {32'h0, rd_data}, 64'ha5c3);
    @(negedge clk); bus_valid = 0;
    @(negedge clk);
    bus_rd(4'd4, 1'b0, d);
    chk("R5 new value", {32'h0, d}, 64'h3c5a);
    bus_wr(4'd4, 32'h0000_ffff, 1'b0);
    bus_rd(4'd4, 1'b0, d);
    chk("R5 write ignored", {32'h0, d}, 64'h3c5a);

    // R9..R11 secure pins
    bus_wr(4'd12, 32'h0000_8009, 1'b0);
    rd_chk("R9 sec readback", 4'd12, 1'b1);
    bus_wr(4'd12, 32'h0000_0000, 1'b1);
    rd_chk("R9 nonsec sec write ignored", 4'd12, 1'b0);
    bus_wr(4'd0, 32'h0000_0000, 1'b1);
    rd_chk("R10 mode secure kept", 4'd0, 1'b0);
    bus_wr(4'd6, 32'hffff_0000, 1'b1);
    chk("R10 bsrr blocked", {48'h0, pad_out & 16'h8009}, {48'h0, b_odr & 16'h8009});
    rd_chk("R11 mode masked", 4'd0, 1'b1);
    rd_chk("R11 odr masked", 4'd5, 1'b1);
    rd_chk("R11 afhi masked", 4'd9, 1'b1);
    bus_wr(4'd6, 32'h0000_0009, 1'b0);
    rd_chk("R10 secure access ok", 4'd5, 1'b0);
    pads_chk("R10 pads");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      bit ns;
      a = addrs[$urandom % 12];
      ns = $urandom % 2;
      if ($urandom % 2) begin
        bus_wr(a, $urandom, ns);
        pads_chk("R10 random");
      end else begin
        rd_chk("R11 random read", a, ns);
      end
    end

    done = 1;
    summary();
  end
endmodule